// File: doc/BRIEF.md
# JTAG Scan Monitor

A passive observer that sits beside a JTAG test port and follows what the test controller does with it. The four port lines (test clock, mode select, data in, data out) and an optional active-low port reset are taken in as plain inputs and brought into the system clock domain through two-flop synchronizers. Rising edges of the test clock are found in that domain, so the system clock has to run at least four times faster than the test clock. The monitor never drives any port line.

At every rising test-clock edge the monitor advances its own copy of the sixteen-state TAP controller, using the mode-select level sampled at that edge. It shows the state as a 4-bit code and pulses a step strobe. While a Shift state is held from one edge to the next, it emits a per-bit strobe with the data-in and data-out levels and stores both bits in accumulators. When Shift is left for Exit1, it emits one completion report. The report carries an instruction/data tag, both collected vectors (the first bit in the least significant position), the number of bits shifted, and an overflow flag. Scans longer than the accumulator width keep counting, but their extra bits are dropped.

Top module: `jtag_scan_monitor`

## Requirements
- R1: After a synchronous reset the state code is 1 (Run-Test/Idle), and the step, bit and completion strobes are low.
- R2: State codes: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2..8 DR Select, Capture, Shift, Exit1, Pause, Exit2, Update, 9..15 the IR states in that same order. On a rising test-clock edge the next state follows the standard TAP table using the sampled mode-select level.
- R3: Falling test-clock edges, and changes of mode select, data in or data out while the test clock does not rise, leave the state code unchanged.
- R4: step_pulse is high for one cycle on every rising edge except the first rising edge after reset. The state change on that first edge still happens.
- R5: bit_valid pulses only on an edge that stays in Shift-DR or Shift-IR, carrying that edge's data-in and data-out levels. The edge that enters Shift produces no bit.
- R6: A Shift-to-Exit1 edge raises done_valid for one cycle. done_is_ir is 1 for the IR branch. done_count is the number of bits captured since the previous report. The accumulators are then cleared. A Capture-to-Exit1 edge gives no report.
- R7: In done_tdi and done_tdo, the first captured bit is bit 0 and each later bit takes the next higher position. Unused positions read 0.
- R8: Bits beyond MAX_BITS are dropped but still counted, and done_ovf is 1 exactly when done_count exceeds MAX_BITS.
- R9: A low trst_n, after synchronization, forces state code 0, clears both accumulators and suppresses any report on a coinciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Observed test clock |
| tms | input | 1 | Observed mode select |
| tdi | input | 1 | Observed data into the target |
| tdo | input | 1 | Observed data out of the target |
| trst_n | input | 1 | Observed active-low port reset (tie high if unused) |
| state_code | output | 4 | Current TAP state code |
| step_pulse | output | 1 | One-cycle strobe per rising test-clock edge |
| bit_valid | output | 1 | One-cycle strobe per captured shift bit |
| bit_tdi | output | 1 | Data-in level of the captured bit |
| bit_tdo | output | 1 | Data-out level of the captured bit |
| done_valid | output | 1 | One-cycle completion strobe |
| done_is_ir | output | 1 | 1 for an IR scan, 0 for a DR scan |
| done_tdi | output | MAX_BITS | Collected data-in vector |
| done_tdo | output | MAX_BITS | Collected data-out vector |
| done_count | output | CNT_W | Bits shifted in the finished scan |
| done_ovf | output | 1 | Scan was longer than MAX_BITS |

## Verification
Two pairs of functions can land in the same cycle. The first is the port reset and the Shift-to-Exit1 edge: the bench lowers trst_n in the very cycle it raises the test clock with mode select high, so both pass through the synchronizer together. It then expects state code 0, no report, and a following scan whose count starts from zero. The second is the overflow drop and the bit strobe: scan lengths are swept from 0 to beyond MAX_BITS on both branches, and for each length the bench computes the masked vectors, the count and the overflow flag arithmetically.

// File: rtl/jtag_mon_pkg.sv
package jtag_mon_pkg;

    typedef enum logic [3:0] {
        TAP_RESET      = 4'd0,
        TAP_IDLE       = 4'd1,
        TAP_DR_SELECT  = 4'd2,
        TAP_DR_CAPTURE = 4'd3,
        TAP_DR_SHIFT   = 4'd4,
        TAP_DR_EXIT1   = 4'd5,
        TAP_DR_PAUSE   = 4'd6,
        TAP_DR_EXIT2   = 4'd7,
        TAP_DR_UPDATE  = 4'd8,
        TAP_IR_SELECT  = 4'd9,
        TAP_IR_CAPTURE = 4'd10,
        TAP_IR_SHIFT   = 4'd11,
        TAP_IR_EXIT1   = 4'd12,
        TAP_IR_PAUSE   = 4'd13,
        TAP_IR_EXIT2   = 4'd14,
        TAP_IR_UPDATE  = 4'd15
    } tap_state_e;

    // Port lines as seen after synchronization.
    typedef struct packed {
        logic trst;   // active-high inside the block
        logic tck;
        logic tms;
        logic tdi;
        logic tdo;
    } jtag_pins_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TAP_RESET:      n = m ? TAP_RESET      : TAP_IDLE;
            TAP_IDLE:       n = m ? TAP_DR_SELECT  : TAP_IDLE;
            TAP_DR_SELECT:  n = m ? TAP_IR_SELECT  : TAP_DR_CAPTURE;
            TAP_DR_CAPTURE: n = m ? TAP_DR_EXIT1   : TAP_DR_SHIFT;
            TAP_DR_SHIFT:   n = m ? TAP_DR_EXIT1   : TAP_DR_SHIFT;
            TAP_DR_EXIT1:   n = m ? TAP_DR_UPDATE  : TAP_DR_PAUSE;
            TAP_DR_PAUSE:   n = m ? TAP_DR_EXIT2   : TAP_DR_PAUSE;
            TAP_DR_EXIT2:   n = m ? TAP_DR_UPDATE  : TAP_DR_SHIFT;
            TAP_DR_UPDATE:  n = m ? TAP_DR_SELECT  : TAP_IDLE;
            TAP_IR_SELECT:  n = m ? TAP_RESET      : TAP_IR_CAPTURE;
            TAP_IR_CAPTURE: n = m ? TAP_IR_EXIT1   : TAP_IR_SHIFT;
            TAP_IR_SHIFT:   n = m ? TAP_IR_EXIT1   : TAP_IR_SHIFT;
            TAP_IR_EXIT1:   n = m ? TAP_IR_UPDATE  : TAP_IR_PAUSE;
            TAP_IR_PAUSE:   n = m ? TAP_IR_EXIT2   : TAP_IR_PAUSE;
            TAP_IR_EXIT2:   n = m ? TAP_IR_UPDATE  : TAP_IR_SHIFT;
            default:        n = m ? TAP_DR_SELECT  : TAP_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == TAP_DR_SHIFT) || (s == TAP_IR_SHIFT);
    endfunction

    function automatic logic is_exit1(input tap_state_e s);
        return (s == TAP_DR_EXIT1) || (s == TAP_IR_EXIT1);
    endfunction

    function automatic logic is_ir_branch(input tap_state_e s);
        return s >= TAP_IR_SELECT;
    endfunction

endpackage

// File: rtl/jtag_mon_sync.sv
module jtag_mon_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/jtag_mon_tap.sv
module jtag_mon_tap
    import jtag_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_i,
    input  logic       tms_i,
    input  logic       trst_i,
    output tap_state_e state_o,
    output tap_state_e state_nxt_o,
    output logic       step_o
);
    tap_state_e state_q;
    logic       seen_edge_q;
    logic       step_q;

    assign state_nxt_o = tap_next(state_q, tms_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TAP_IDLE;
            seen_edge_q <= 1'b0;
            step_q      <= 1'b0;
        end else if (trst_i) begin
            state_q <= TAP_RESET;
            step_q  <= 1'b0;
        end else begin
            step_q <= rise_i && seen_edge_q;
            if (rise_i) begin
                state_q     <= state_nxt_o;
                seen_edge_q <= 1'b1;
            end
        end
    end

    assign state_o = state_q;
    assign step_o  = step_q;

    p_hold_without_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (!rise_i && !trst_i) |=> $stable(state_q));

    p_trst_forces_reset_r9: assert property (@(posedge clk) disable iff (rst)
        trst_i |=> (state_q == TAP_RESET));

    p_step_single_r4: assert property (@(posedge clk) disable iff (rst)
        step_q |=> !step_q);
endmodule

// File: rtl/jtag_mon_capture.sv
module jtag_mon_capture
    import jtag_mon_pkg::*;
#(
    parameter int MAX_BITS = 64,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                adv_i,
    input  tap_state_e          cur_i,
    input  tap_state_e          nxt_i,
    input  logic                tdi_i,
    input  logic                tdo_i,
    output logic                bit_valid_o,
    output logic                bit_tdi_o,
    output logic                bit_tdo_o,
    output logic                done_valid_o,
    output logic                done_is_ir_o,
    output logic [MAX_BITS-1:0] done_tdi_o,
    output logic [MAX_BITS-1:0] done_tdo_o,
    output logic [CNT_W-1:0]    done_count_o,
    output logic                done_ovf_o
);
    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT   = '1;

    logic [MAX_BITS-1:0] acc_tdi_q, acc_tdo_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                ovf_q;

    logic stay_shift, leave_shift, room;

    assign stay_shift  = adv_i && is_shift(cur_i) && (nxt_i == cur_i);
    assign leave_shift = adv_i && is_shift(cur_i) && is_exit1(nxt_i);
    assign room        = cnt_q < CNT_LIMIT;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_tdi_q    <= '0;
            acc_tdo_q    <= '0;
            cnt_q        <= '0;
            ovf_q        <= 1'b0;
            bit_valid_o  <= 1'b0;
            bit_tdi_o    <= 1'b0;
            bit_tdo_o    <= 1'b0;
            done_valid_o <= 1'b0;
            if (rst) begin
                done_is_ir_o <= 1'b0;
                done_tdi_o   <= '0;
                done_tdo_o   <= '0;
                done_count_o <= '0;
                done_ovf_o   <= 1'b0;
            end
        end else begin
            bit_valid_o  <= 1'b0;
            done_valid_o <= 1'b0;
            if (stay_shift) begin
                bit_valid_o <= 1'b1;
                bit_tdi_o   <= tdi_i;
                bit_tdo_o   <= tdo_i;
                if (room) begin
                    acc_tdi_q[cnt_q[IDX_W-1:0]] <= tdi_i;
                    acc_tdo_q[cnt_q[IDX_W-1:0]] <= tdo_i;
                end else begin
                    ovf_q <= 1'b1;
                end
                if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
            end
            if (leave_shift) begin
                done_valid_o <= 1'b1;
                done_is_ir_o <= is_ir_branch(cur_i);
                done_tdi_o   <= acc_tdi_q;
                done_tdo_o   <= acc_tdo_q;
                done_count_o <= cnt_q;
                done_ovf_o   <= ovf_q;
                acc_tdi_q    <= '0;
                acc_tdo_q    <= '0;
                cnt_q        <= '0;
                ovf_q        <= 1'b0;
            end
        end
    end

    p_ovf_matches_count_r8: assert property (@(posedge clk) disable iff (rst)
        done_valid_o |-> (done_ovf_o == (done_count_o > CNT_LIMIT)));

    p_no_bit_and_done_r6: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid_o && done_valid_o));
endmodule

// File: rtl/jtag_scan_monitor.sv
module jtag_scan_monitor
    import jtag_mon_pkg::*;
#(
    parameter int MAX_BITS = 64,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tck,
    input  logic                tms,
    input  logic                tdi,
    input  logic                tdo,
    input  logic                trst_n,
    output logic [3:0]          state_code,
    output logic                step_pulse,
    output logic                bit_valid,
    output logic                bit_tdi,
    output logic                bit_tdo,
    output logic                done_valid,
    output logic                done_is_ir,
    output logic [MAX_BITS-1:0] done_tdi,
    output logic [MAX_BITS-1:0] done_tdo,
    output logic [CNT_W-1:0]    done_count,
    output logic                done_ovf
);
    localparam int PIN_W = $bits(jtag_pins_t);

    jtag_pins_t raw_pins, pins;
    logic       tck_prev_q;
    logic       rise, adv;
    tap_state_e state, state_nxt;

    assign raw_pins = '{trst: ~trst_n, tck: tck, tms: tms, tdi: tdi, tdo: tdo};

    jtag_mon_sync #(.WIDTH(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) tck_prev_q <= 1'b0;
        else     tck_prev_q <= pins.tck;
    end

    assign rise = pins.tck && !tck_prev_q;
    assign adv  = rise && !pins.trst;

    jtag_mon_tap u_tap (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (rise),
        .tms_i       (pins.tms),
        .trst_i      (pins.trst),
        .state_o     (state),
        .state_nxt_o (state_nxt),
        .step_o      (step_pulse)
    );

    jtag_mon_capture #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .clr_i        (pins.trst),
        .adv_i        (adv),
        .cur_i        (state),
        .nxt_i        (state_nxt),
        .tdi_i        (pins.tdi),
        .tdo_i        (pins.tdo),
        .bit_valid_o  (bit_valid),
        .bit_tdi_o    (bit_tdi),
        .bit_tdo_o    (bit_tdo),
        .done_valid_o (done_valid),
        .done_is_ir_o (done_is_ir),
        .done_tdi_o   (done_tdi),
        .done_tdo_o   (done_tdo),
        .done_count_o (done_count),
        .done_ovf_o   (done_ovf)
    );

    assign state_code = state;

    p_bit_in_shift_r5: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> is_shift(state));

    p_done_in_exit1_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (is_exit1(state) && (done_is_ir == is_ir_branch(state))));

    p_done_with_step_r4: assert property (@(posedge clk) disable iff (rst)
        (done_valid || bit_valid) |-> step_pulse);
endmodule

// File: tb/jtag_scan_monitor_test.sv
module jtag_scan_monitor_test;
    localparam int MB = 8;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo = 1'b0, trst_n = 1'b1;
    logic [3:0]    state_code;
    logic          step_pulse, bit_valid, bit_tdi, bit_tdo;
    logic          done_valid, done_is_ir, done_ovf;
    logic [MB-1:0] done_tdi, done_tdo;
    logic [CW-1:0] done_count;

    always #5 clk = ~clk;

    jtag_scan_monitor #(.MAX_BITS(MB), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .trst_n(trst_n), .state_code(state_code), .step_pulse(step_pulse),
        .bit_valid(bit_valid), .bit_tdi(bit_tdi), .bit_tdo(bit_tdo),
        .done_valid(done_valid), .done_is_ir(done_is_ir), .done_tdi(done_tdi),
        .done_tdo(done_tdo), .done_count(done_count), .done_ovf(done_ovf)
    );

    int tests = 0, fails = 0;
    bit finished = 0;
    int step_n = 0, bit_n = 0, done_n = 0;
    logic last_bit_tdi, last_bit_tdo, l_ir, l_ovf;
    logic [MB-1:0] l_tdi, l_tdo;
    logic [CW-1:0] l_cnt;

    // observers, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (step_pulse) step_n++;
            if (bit_valid) begin
                bit_n++;
                last_bit_tdi = bit_tdi;
                last_bit_tdo = bit_tdo;
            end
            if (done_valid) begin
                done_n++;
                l_ir = done_is_ir; l_tdi = done_tdi; l_tdo = done_tdo;
                l_cnt = done_count; l_ovf = done_ovf;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] mdl_next(input logic [3:0] s, input logic m);
        case (s)
            4'd0:  return m ? 4'd0 : 4'd1;
            4'd1:  return m ? 4'd2 : 4'd1;
            4'd2:  return m ? 4'd9 : 4'd3;
            4'd9:  return m ? 4'd0 : 4'd10;
            4'd8, 4'd15: return m ? 4'd2 : 4'd1;
            default: begin
                // branch-relative: 0 capture,1 shift,2 exit1,3 pause,4 exit2
                logic [3:0] base;
                logic [3:0] off;
                base = (s >= 4'd9) ? 4'd10 : 4'd3;
                off  = s - base;
                case (off)
                    4'd0, 4'd1: return m ? base + 4'd2 : base + 4'd1;
                    4'd2:       return m ? base + 4'd5 : base + 4'd3;
                    4'd3:       return m ? base + 4'd4 : base + 4'd3;
                    default:    return m ? base + 4'd5 : base + 4'd1;
                endcase
            end
        endcase
    endfunction

    task automatic edge_tck(input logic m, input logic di, input logic dout);
        @(negedge clk);
        tms = m; tdi = di; tdo = dout;
        repeat (4) @(negedge clk);
        tck = 1'b1;
        repeat (4) @(negedge clk);
        tck = 1'b0;
    endtask

    task automatic to_reset();
        for (int i = 0; i < 5; i++) edge_tck(1'b1, 1'b0, 1'b0);
    endtask

    task automatic go_state(input int s);
        logic [7:0] pb;
        int pl;
        case (s)
            0: begin pb = 8'd0;  pl = 0; end
            1: begin pb = 8'd0;  pl = 1; end
            2: begin pb = 8'd2;  pl = 2; end
            3: begin pb = 8'd2;  pl = 3; end
            4: begin pb = 8'd2;  pl = 4; end
            5: begin pb = 8'd10; pl = 4; end
            6: begin pb = 8'd10; pl = 5; end
            7: begin pb = 8'd42; pl = 6; end
            8: begin pb = 8'd26; pl = 5; end
            9: begin pb = 8'd6;  pl = 3; end
            10: begin pb = 8'd6;  pl = 4; end
            11: begin pb = 8'd6;  pl = 5; end
            12: begin pb = 8'd22; pl = 5; end
            13: begin pb = 8'd22; pl = 6; end
            14: begin pb = 8'd86; pl = 7; end
            default: begin pb = 8'd54; pl = 6; end
        endcase
        to_reset();
        for (int i = 0; i < pl; i++) edge_tck(pb[i], 1'b0, 1'b0);
    endtask

    task automatic do_scan(input logic ir, input int n, input logic [15:0] pi, input logic [15:0] po);
        int b0, d0, k;
        logic [MB-1:0] mask;
        go_state(ir ? 10 : 3);
        b0 = bit_n;
        edge_tck(1'b0, 1'b1, 1'b1);       // enter Shift, no capture
        check("R5 entry edge captures nothing", 64'(bit_n), 64'(b0));
        d0 = done_n;
        for (int i = 0; i < n; i++) edge_tck(1'b0, pi[i], po[i]);
        check("R5 bit strobes per held shift", 64'(bit_n - b0), 64'(n));
        if (n > 0) begin
            check("R5 last bit tdi", 64'(last_bit_tdi), 64'(pi[n-1]));
            check("R5 last bit tdo", 64'(last_bit_tdo), 64'(po[n-1]));
        end
        edge_tck(1'b1, ~pi[0], ~po[0]);  // Shift -> Exit1
        check("R6 one report", 64'(done_n - d0), 64'd1);
        check("R6 tag", 64'(l_ir), 64'(ir));
        check("R6 count", 64'(l_cnt), 64'(n));
        k = (n < MB) ? n : MB;
        mask = MB'((64'd1 << k) - 64'd1);
        check("R7 tdi vector", 64'(l_tdi), 64'(pi[MB-1:0] & mask));
        check("R7 tdo vector", 64'(l_tdo), 64'(po[MB-1:0] & mask));
        check("R8 overflow flag", 64'(l_ovf), 64'(n > MB));
        check("R2 lands in Exit1", 64'(state_code), ir ? 64'd12 : 64'd5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0, d0;
        logic [15:0] p1, p2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 reset state Idle", 64'(state_code), 64'd1);
        check("R1 no strobes", 64'({step_n != 0, bit_valid, done_valid}), 64'd0);

        // R4 first edge moves state but gives no step
        edge_tck(1'b1, 1'b0, 1'b0);
        check("R4 first edge state", 64'(state_code), 64'd2);
        check("R4 first edge no step", 64'(step_n), 64'd0);
        edge_tck(1'b1, 1'b0, 1'b0);
        check("R4 second edge steps", 64'(step_n), 64'd1);
        check("R2 Select-DR to Select-IR", 64'(state_code), 64'd9);

        // R3 no rising edge: wiggle inputs, then change TMS while high before fall
        to_reset();
        edge_tck(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tms = i[0]; tdi = i[1]; tdo = i[2];
        end
        repeat (4) @(negedge clk);
        check("R3 stable without edge", 64'(state_code), 64'd1);
        tms = 1'b0;
        repeat (4) @(negedge clk);
        tck = 1'b1;
        repeat (4) @(negedge clk);
        tms = 1'b1;
        repeat (4) @(negedge clk);
        tck = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 falling edge ignored", 64'(state_code), 64'd1);

        // R2 full transition sweep
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 2; m++) begin
                go_state(s);
                check("R2 reach state", 64'(state_code), 64'(s));
                s0 = step_n;
                edge_tck(m[0], 1'b0, 1'b0);
                check("R2 next state", 64'(state_code), 64'(mdl_next(4'(s), m[0])));
                check("R4 one step per edge", 64'(step_n - s0), 64'd1);
            end
        end

        // R6 Capture -> Exit1 gives no report
        go_state(3);
        d0 = done_n;
        edge_tck(1'b1, 1'b0, 1'b0);
        check("R6 capture-exit1 silent", 64'(done_n - d0), 64'd0);

        // R5..R8 length sweep on both branches
        for (int n = 0; n <= 11; n++) begin
            p1 = 16'hA5C3 ^ 16'(n * 37);
            p2 = 16'h3C96 ^ 16'(n * 91);
            do_scan(1'b0, n, p1, p2);
            do_scan(1'b1, n, ~p1, p2 ^ 16'h0F0F);
        end

        // R6 pause splits a scan; Exit2 -> Shift edge does not capture
        go_state(10);
        edge_tck(1'b0, 1'b0, 1'b0);                 // Shift-IR
        edge_tck(1'b0, 1'b1, 1'b0);
        edge_tck(1'b0, 1'b0, 1'b1);
        edge_tck(1'b0, 1'b1, 1'b1);
        d0 = done_n;
        edge_tck(1'b1, 1'b0, 1'b0);                 // Exit1
        check("R6 first part count", 64'(l_cnt), 64'd3);
        check("R7 first part tdi", 64'(l_tdi), 64'h5);
        edge_tck(1'b0, 1'b0, 1'b0);                 // Pause
        edge_tck(1'b1, 1'b0, 1'b0);                 // Exit2
        edge_tck(1'b0, 1'b1, 1'b1);                 // Shift, no capture
        edge_tck(1'b0, 1'b0, 1'b1);
        edge_tck(1'b0, 1'b1, 1'b0);
        edge_tck(1'b1, 1'b0, 1'b0);
        check("R6 second report", 64'(done_n - d0), 64'd2);
        check("R6 cleared count", 64'(l_cnt), 64'd2);
        check("R7 second part tdi", 64'(l_tdi), 64'h2);
        check("R7 second part tdo", 64'(l_tdo), 64'h1);

        // R9 port reset coinciding with Shift -> Exit1 edge
        go_state(3);
        edge_tck(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) edge_tck(1'b0, 1'b1, 1'b1);
        d0 = done_n;
        @(negedge clk);
        tms = 1'b1;
        trst_n = 1'b0;
        tck = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 no report on reset edge", 64'(done_n - d0), 64'd0);
        check("R9 forced Test-Logic-Reset", 64'(state_code), 64'd0);
        tck = 1'b0;
        repeat (3) @(negedge clk);
        trst_n = 1'b1;
        repeat (4) @(negedge clk);
        go_state(3);
        edge_tck(1'b0, 1'b0, 1'b0);
        edge_tck(1'b0, 1'b1, 1'b0);
        edge_tck(1'b0, 1'b0, 1'b1);
        edge_tck(1'b1, 1'b0, 1'b0);
        check("R9 accumulators cleared", 64'(l_cnt), 64'd2);
        check("R9 vector after clear", 64'(l_tdi), 64'h1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule